// File: doc/BRIEF.md
# Pointer Address Generator with Circular and Bit-Reversed Modes

This block produces data-memory addresses for a signal-processing datapath. It keeps a small file of address pointers. On each access it reports the current value of the selected pointer as the effective address. In the same cycle it writes back a modified pointer, computed in one of four ways:

- **Plain add:** add a signed step.
- **Circular add:** add a signed step and wrap inside a buffer given by a start address and a length. This serves filter delay lines, where the newest sample overwrites the oldest and the index then moves on.
- **Reversed-carry add:** add half the transform size, with the carry running from high bits to low bits. This walks FFT data in bit-reversed order.
- **Hold:** read the pointer without changing it.

Pointers can also be written directly through a load port.

Results are registered. The effective address and the modified pointer for a request appear on the outputs one clock after the request, with a valid flag. A load issued in the same cycle as an update wins, and the update is discarded.

Top module: `dsp_addr_gen`

## Requirements
- R1: After reset every pointer reads as zero, `out_valid` is 0, and `eff_addr` and `new_ptr` are 0.
- R2: A load writes `ld_value` into pointer `ld_sel`. The next update of that pointer reports `ld_value` as its effective address.
- R3: In a cycle with `ld_valid` high, any update request is discarded. `out_valid` is 0 in the following cycle, and no pointer other than the loaded one changes.
- R4: Mode code 0 (plain add) writes back `ptr + step`, with `step` taken as two's complement and the sum taken modulo 2^32.
- R5: Mode code 1 (circular add) with a non-negative step: when `ptr + step` reaches or passes `buf_base + buf_len`, the result is `ptr + step - buf_len`; otherwise it is `ptr + step`.
- R6: Mode code 1 with a negative step: when `ptr + step` falls below `buf_base`, the result is `ptr + step + buf_len`.
- R7: Mode code 2 (reversed-carry add) adds 2^(`fft_lg`-1) to the pointer, with the carry propagating from bit 31 toward bit 0 and dropped past bit 0. When `fft_lg` is 0 the pointer is unchanged.
- R8: One clock after an accepted update, `out_valid` is 1, `eff_addr` holds the pointer value before the update, and `new_ptr` holds the written-back value. Back-to-back updates chain without gaps.
- R9: Mode code 3 (hold) leaves the pointer unchanged and reports it on both `eff_addr` and `new_ptr`.
- R10: An update changes only the selected pointer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| upd_valid | input | 1 | Access request: report and modify a pointer |
| upd_sel | input | 3 | Pointer index for the request |
| upd_mode | input | 2 | 0 plain, 1 circular, 2 reversed-carry, 3 hold |
| upd_step | input | 32 | Signed step for modes 0 and 1 |
| buf_base | input | 32 | Circular buffer start address |
| buf_len | input | 32 | Circular buffer length |
| fft_lg | input | 6 | log2 of the transform size for mode 2 |
| ld_valid | input | 1 | Direct pointer write |
| ld_sel | input | 3 | Pointer index to write |
| ld_value | input | 32 | Value to write |
| out_valid | output | 1 | Registered: previous cycle's request was accepted |
| eff_addr | output | 32 | Registered pointer value before modification |
| new_ptr | output | 32 | Registered modified pointer value |

## Verification
A corrupted pointer register does not show up when it is corrupted. It shows up at the next request that selects that pointer, as a wrong `eff_addr` one clock after the request. A wrong modifier result appears at once on `new_ptr`, and again as `eff_addr` on the following access. A fault in the wrap or reversed-carry logic is therefore exposed within one access when the step crosses the buffer end. In the reversed-carry case it is exposed on the second step of a sequence, where the carry first moves downward. Comparing both outputs against a behavioural model on every clock catches these faults, as well as pointers that leak into one another.

// File: rtl/agu_pkg.sv
package agu_pkg;
  typedef enum logic [1:0] {
    MODE_LIN  = 2'b00,
    MODE_CIRC = 2'b01,
    MODE_REV  = 2'b10,
    MODE_HOLD = 2'b11
  } agu_mode_e;
endpackage

// File: rtl/agu_ptr_file.sv
module agu_ptr_file #(
  parameter int NUM = 8,
  parameter int AW  = 32,
  localparam int SW = $clog2(NUM)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          we,
  input  logic [SW-1:0] wsel,
  input  logic [AW-1:0] wdata,
  input  logic [SW-1:0] rsel,
  output logic [AW-1:0] rdata
);
  logic [AW-1:0] regs [NUM];

  for (genvar g = 0; g < NUM; g++) begin : g_reg
    always_ff @(posedge clk) begin
      if (rst)
        regs[g] <= '0;
      else if (we && wsel == SW'(g))
        regs[g] <= wdata;
    end
  end

  assign rdata = regs[rsel];
endmodule

// File: rtl/agu_circ.sv
module agu_circ #(
  parameter int AW = 32
) (
  input  logic [AW-1:0] ptr,
  input  logic [AW-1:0] step,
  input  logic [AW-1:0] base,
  input  logic [AW-1:0] len,
  output logic [AW-1:0] nxt
);
  logic [AW-1:0] sum;
  logic [AW-1:0] lim;
  logic          neg;

  always_comb begin
    sum = ptr + step;
    lim = base + len;
    neg = step[AW-1];
    if (!neg && sum >= lim)
      nxt = sum - len;
    else if (neg && sum < base)
      nxt = sum + len;
    else
      nxt = sum;
  end
endmodule

// File: rtl/agu_revcarry.sv
module agu_revcarry #(
  parameter int AW   = 32,
  localparam int LW = $clog2(AW) + 1
) (
  input  logic [AW-1:0] ptr,
  input  logic [LW-1:0] lg,
  output logic [AW-1:0] nxt
);
  logic [AW-1:0] inc, ptr_r, inc_r, sum_r;

  always_comb begin
    inc = '0;
    if (lg != '0 && int'(lg) <= AW)
      inc[int'(lg) - 1] = 1'b1;
  end

  for (genvar i = 0; i < AW; i++) begin : g_swap
    assign ptr_r[i] = ptr[AW-1-i];
    assign inc_r[i] = inc[AW-1-i];
    assign nxt[i]   = sum_r[AW-1-i];
  end

  assign sum_r = ptr_r + inc_r;
endmodule

// File: rtl/dsp_addr_gen.sv
module dsp_addr_gen #(
  parameter int NUM_PTR = 8,
  parameter int AW      = 32,
  localparam int SW = $clog2(NUM_PTR),
  localparam int LW = $clog2(AW) + 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          upd_valid,
  input  logic [SW-1:0] upd_sel,
  input  logic [1:0]    upd_mode,
  input  logic [AW-1:0] upd_step,
  input  logic [AW-1:0] buf_base,
  input  logic [AW-1:0] buf_len,
  input  logic [LW-1:0] fft_lg,
  input  logic          ld_valid,
  input  logic [SW-1:0] ld_sel,
  input  logic [AW-1:0] ld_value,
  output logic          out_valid,
  output logic [AW-1:0] eff_addr,
  output logic [AW-1:0] new_ptr
);
  import agu_pkg::*;

  agu_mode_e     mode;
  logic [AW-1:0] cur, nxt, nxt_circ, nxt_rev;
  logic          accept, wr_en;
  logic [SW-1:0] wr_sel;
  logic [AW-1:0] wr_data;

  assign mode   = agu_mode_e'(upd_mode);
  assign accept = upd_valid && !ld_valid;

  agu_ptr_file #(.NUM(NUM_PTR), .AW(AW)) u_file (
    .clk(clk), .rst(rst), .we(wr_en), .wsel(wr_sel), .wdata(wr_data),
    .rsel(upd_sel), .rdata(cur)
  );

  agu_circ #(.AW(AW)) u_circ (
    .ptr(cur), .step(upd_step), .base(buf_base), .len(buf_len), .nxt(nxt_circ)
  );

  agu_revcarry #(.AW(AW)) u_rev (
    .ptr(cur), .lg(fft_lg), .nxt(nxt_rev)
  );

  always_comb begin
    unique case (mode)
      MODE_LIN:  nxt = cur + upd_step;
      MODE_CIRC: nxt = nxt_circ;
      MODE_REV:  nxt = nxt_rev;
      default:   nxt = cur;
    endcase
  end

  always_comb begin
    wr_en   = ld_valid || (accept && mode != MODE_HOLD);
    wr_sel  = ld_valid ? ld_sel : upd_sel;
    wr_data = ld_valid ? ld_value : nxt;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      eff_addr  <= '0;
      new_ptr   <= '0;
    end else begin
      out_valid <= accept;
      if (accept) begin
        eff_addr <= cur;
        new_ptr  <= nxt;
      end
    end
  end

  logic          circ_pre, step_neg;
  logic [AW-1:0] step_mag;
  assign step_neg = upd_step[AW-1];
  assign step_mag = step_neg ? (~upd_step + 1'b1) : upd_step;
  assign circ_pre = accept && mode == MODE_CIRC && cur >= buf_base &&
                    (cur - buf_base) < buf_len && step_mag <= buf_len;

  // R8
  valid_follow_chk: assert property (@(posedge clk) disable iff (rst)
    (upd_valid && !ld_valid) |=> out_valid);

  // R3
  load_wins_chk: assert property (@(posedge clk) disable iff (rst)
    ld_valid |=> !out_valid);

  // R4
  lin_add_chk: assert property (@(posedge clk) disable iff (rst)
    (accept && mode == MODE_LIN) |=> new_ptr == eff_addr + $past(upd_step));

  // R9
  hold_same_chk: assert property (@(posedge clk) disable iff (rst)
    (accept && mode == MODE_HOLD) |=> new_ptr == eff_addr);

  // R5
  circ_range_chk: assert property (@(posedge clk) disable iff (rst)
    circ_pre |=> (new_ptr >= $past(buf_base)) &&
                 ((new_ptr - $past(buf_base)) < $past(buf_len)));

  // R7
  rev_moves_chk: assert property (@(posedge clk) disable iff (rst)
    (accept && mode == MODE_REV && fft_lg != '0 && int'(fft_lg) <= AW)
      |=> new_ptr != eff_addr);
endmodule

// File: tb/test_dsp_addr_gen.sv
module test_dsp_addr_gen;
  localparam int N = 8;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        upd_valid = 1'b0;
  logic [2:0]  upd_sel = '0;
  logic [1:0]  upd_mode = '0;
  logic [31:0] upd_step = '0;
  logic [31:0] buf_base = '0;
  logic [31:0] buf_len = '0;
  logic [5:0]  fft_lg = '0;
  logic        ld_valid = 1'b0;
  logic [2:0]  ld_sel = '0;
  logic [31:0] ld_value = '0;
  logic        out_valid;
  logic [31:0] eff_addr, new_ptr;

  int errors = 0;
  int checks = 0;
  bit done = 0;
  logic [31:0] model [N];

  always #2.5 clk = ~clk;

  dsp_addr_gen i_dsp_addr_gen (
    .clk(clk), .rst(rst), .upd_valid(upd_valid), .upd_sel(upd_sel),
    .upd_mode(upd_mode), .upd_step(upd_step), .buf_base(buf_base),
    .buf_len(buf_len), .fft_lg(fft_lg), .ld_valid(ld_valid), .ld_sel(ld_sel),
    .ld_value(ld_value), .out_valid(out_valid), .eff_addr(eff_addr),
    .new_ptr(new_ptr)
  );

  task automatic check(string tag, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  function automatic logic [31:0] rev_add(logic [31:0] a, logic [31:0] b);
    logic [31:0] r = '0;
    int c = 0;
    for (int i = 31; i >= 0; i--) begin
      int s = int'(a[i]) + int'(b[i]) + c;
      r[i] = s[0];
      c = s / 2;
    end
    return r;
  endfunction

  function automatic logic [31:0] model_next(logic [31:0] p, logic [1:0] m, logic [31:0] st);
    longint sp, sum;
    logic [31:0] inc;
    case (m)
      2'd0: return p + st;
      2'd1: begin
        sp  = longint'($signed(st));
        sum = longint'(p) + sp;
        if (sp >= 0 && sum >= longint'(buf_base) + longint'(buf_len)) sum -= longint'(buf_len);
        else if (sp < 0 && sum < longint'(buf_base)) sum += longint'(buf_len);
        return sum[31:0];
      end
      2'd2: begin
        inc = '0;
        if (fft_lg != 0) inc = 32'd1 << (fft_lg - 1);
        return rev_add(p, inc);
      end
      default: return p;
    endcase
  endfunction

  task automatic cyc(bit ld, int lsel, logic [31:0] lval,
                     bit up, int usel, logic [1:0] m, logic [31:0] st, string tag);
    logic exp_v;
    logic [31:0] exp_e, exp_n;
    @(negedge clk);
    ld_valid = ld; ld_sel = 3'(lsel); ld_value = lval;
    upd_valid = up; upd_sel = 3'(usel); upd_mode = m; upd_step = st;
    exp_v = up && !ld;
    exp_e = model[usel];
    exp_n = model_next(model[usel], m, st);
    @(posedge clk);
    #1;
    if (ld) model[lsel] = lval;
    else if (up) model[usel] = exp_n;
    check(tag, "out_valid", {31'd0, out_valid}, {31'd0, exp_v});
    if (exp_v) begin
      check(tag, "eff_addr", eff_addr, exp_e);
      check(tag, "new_ptr", new_ptr, exp_n);
    end
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < N; i++) model[i] = '0;
    repeat (3) @(posedge clk);
    #1;
    // R1 reset state of the outputs
    check("R1", "out_valid", {31'd0, out_valid}, 32'd0);
    check("R1", "eff_addr", eff_addr, 32'd0);
    check("R1", "new_ptr", new_ptr, 32'd0);
    @(negedge clk); rst = 1'b0;
    // R1 R9 every pointer reads zero via hold
    for (int i = 0; i < N; i++) cyc(0, 0, 0, 1, i, 2'd3, 32'd0, "R1");
    // R2 load, R4 plain add, R8 back-to-back
    cyc(1, 0, 32'h1000, 0, 0, 2'd0, 0, "R2");
    cyc(0, 0, 0, 1, 0, 2'd0, 32'd8, "R2");
    cyc(0, 0, 0, 1, 0, 2'd0, 32'd8, "R8");
    cyc(0, 0, 0, 1, 0, 2'd0, -32'sd4, "R4");
    cyc(1, 5, 32'hFFFF_FFFC, 0, 0, 2'd0, 0, "R2");
    cyc(0, 0, 0, 1, 5, 2'd0, 32'd8, "R4");
    // R10 pointer 0 unaffected by pointer 5
    cyc(0, 0, 0, 1, 0, 2'd3, 0, "R10");
    // R5 circular, positive step
    buf_base = 32'h200; buf_len = 32'd5;
    cyc(1, 1, 32'h200, 0, 0, 2'd0, 0, "R2");
    for (int i = 0; i < 7; i++) cyc(0, 0, 0, 1, 1, 2'd1, 32'd1, "R5");
    for (int i = 0; i < 4; i++) cyc(0, 0, 0, 1, 1, 2'd1, 32'd2, "R5");
    cyc(0, 0, 0, 1, 1, 2'd1, 32'd5, "R5");
    // R6 circular, negative step
    cyc(1, 1, 32'h200, 0, 0, 2'd0, 0, "R2");
    for (int i = 0; i < 4; i++) cyc(0, 0, 0, 1, 1, 2'd1, -32'sd1, "R6");
    cyc(0, 0, 0, 1, 1, 2'd1, -32'sd3, "R6");
    // R7 reversed-carry, N=8 then N=16
    fft_lg = 6'd3;
    cyc(1, 2, 32'h40, 0, 0, 2'd0, 0, "R2");
    for (int i = 0; i < 9; i++) cyc(0, 0, 0, 1, 2, 2'd2, 0, "R7");
    fft_lg = 6'd4;
    cyc(1, 2, 32'h100, 0, 0, 2'd0, 0, "R2");
    for (int i = 0; i < 17; i++) cyc(0, 0, 0, 1, 2, 2'd2, 0, "R7");
    fft_lg = 6'd0;
    cyc(0, 0, 0, 1, 2, 2'd2, 0, "R7");
    // R3 load beats update, same and different pointer
    cyc(1, 0, 32'h5555, 1, 0, 2'd0, 32'd8, "R3");
    cyc(0, 0, 0, 1, 0, 2'd3, 0, "R3");
    cyc(1, 4, 32'h77, 1, 1, 2'd0, 32'd8, "R3");
    cyc(0, 0, 0, 1, 1, 2'd3, 0, "R3");
    cyc(0, 0, 0, 1, 4, 2'd3, 0, "R3");
    // R9 hold then R10 final sweep
    cyc(0, 0, 0, 1, 5, 2'd3, 0, "R9");
    for (int i = 0; i < N; i++) cyc(0, 0, 0, 1, i, 2'd3, 0, "R10");
    @(negedge clk); upd_valid = 1'b0;
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule